// File: doc/BRIEF.md
# Vertical Count-Down Divider with Search and Standard Windows

This block turns separated vertical sync pulses into a clean vertical output pulse for a video timing chain. It is clocked at twice the line rate, so one clock cycle is one half-line and every count in this brief is in half-lines. A counter measures the distance from the last field start. Incoming sync is accepted only inside a timing window, and the window depends on the lock state.

In search mode the window is wide: 244 to 288 lines. When no sync comes, the divider restarts by itself every 262.5 lines. After a run of standard-length fields it moves to standard mode. There the window is narrow, syncs outside it are ignored, and a missing sync is replaced by a pulse that the divider inserts itself at the window's end. A run of missed fields sends it back to search mode.

The block also reports the measured length of each accepted field. It does not separate sync from video and does not integrate the vertical sync.

Top module: `vsync_countdown`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `vout_o` is 0, `std_mode_o` is 0 (search mode) and `field_len_o` is 0.
- R2: In search mode with no accepted sync, the divider restarts every 525 cycles, and each restart produces an output pulse.
- R3: Every restart drives `vout_o` high for exactly 12 cycles. The pulse starts in the cycle after the clock edge at which the restart happens. A new restart during a pulse starts a fresh 12-cycle pulse.
- R4: A sync edge is a clock edge at which `vsync_i` is 1 and was 0 at the previous edge. In search mode a sync edge is accepted, and restarts the divider at that edge, when its measured length is from 488 to 576. The measured length is the count since the last restart. If the last restart was self-generated and that count is below 488, the measured length is the self-generated field's length plus that count. Sync edges with any other length are ignored.
- R5: Each accepted sync loads its measured length into `field_len_o`. Otherwise `field_len_o` holds its value, including at inserted pulses.
- R6: In search mode, 16 successive accepted syncs whose lengths are all from 522 to 528 switch the block to standard mode (`std_mode_o` = 1) at the 16th. An accepted sync with any other length resets this run to zero.
- R7: In standard mode a sync edge is accepted only when the count since the last restart is from 522 to 528. Other sync edges neither restart the divider nor change any output.
- R8: In standard mode, if no sync has been accepted by count 528, the divider inserts a restart at count 528. An accepted sync at count 528 takes priority over the insertion.
- R9: Six successive inserted restarts in standard mode return the block to search mode at the sixth. An accepted sync resets this run to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-line clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Separated vertical sync, active high |
| vout_o | output | 1 | Vertical output pulse |
| std_mode_o | output | 1 | 1 in standard (narrow window) mode, 0 in search mode |
| field_len_o | output | 10 | Length in half-lines of the last accepted field |

## Verification
The hardest situation to reach is a sync that arrives after the divider has already restarted by itself in search mode. Such a sync can only be accepted by adding the stored length of the self-generated field, and it must be told apart from a sync that is too late. The bench gets there by anchoring each sync to the observed time of a self-generated pulse. It then places syncs at the largest total length that is still accepted and at one count beyond it. The same late path is used to break a run of standard fields with a 540-count field, and the bench then shows that 16 further standard fields are needed before standard mode is entered. The exit path is reached by starving standard mode of sync for six windows, with ignored syncs placed one count before the window and mid-field along the way.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  typedef enum logic {
    MODE_SEARCH = 1'b0,
    MODE_STD    = 1'b1
  } div_mode_t;
endpackage

// File: rtl/vdiv_window.sv
// Window decode: decides, from the half-line count, whether a sync edge is
// accepted and whether the flywheel must restart the field itself.
module vdiv_window
  import vdiv_pkg::*;
#(
  parameter int CW       = 10,
  parameter int FREE_LEN = 525,
  parameter int SRCH_LO  = 488,
  parameter int SRCH_HI  = 576,
  parameter int WIN_LO   = 522,
  parameter int WIN_HI   = 528
) (
  input  div_mode_t     mode,
  input  logic          edge_det,
  input  logic [CW-1:0] hcnt,
  input  logic          was_wrap,
  input  logic [CW-1:0] wrap_len,
  output logic          accept,
  output logic          insert,
  output logic          is_std,
  output logic [CW:0]   len_sel
);
  localparam int SW = CW + 1;

  logic [SW-1:0] h_ext;
  logic [SW-1:0] late_len;
  logic          in_search_win;
  logic          in_std_win;

  always_comb begin
    h_ext    = {1'b0, hcnt};
    late_len = h_ext + {1'b0, wrap_len};
    len_sel  = h_ext;
    // a sync early in a self-started field may still close the previous one
    if (mode == MODE_SEARCH && was_wrap && h_ext < SW'(SRCH_LO))
      len_sel = late_len;
    in_search_win = (len_sel >= SW'(SRCH_LO)) && (len_sel <= SW'(SRCH_HI));
    in_std_win    = (h_ext >= SW'(WIN_LO)) && (h_ext <= SW'(WIN_HI));
    is_std        = (len_sel >= SW'(WIN_LO)) && (len_sel <= SW'(WIN_HI));
    if (mode == MODE_STD) begin
      accept = edge_det && in_std_win;
      insert = !accept && (h_ext >= SW'(WIN_HI));
    end else begin
      accept = edge_det && in_search_win;
      insert = !accept && (h_ext >= SW'(FREE_LEN));
    end
  end
endmodule

// File: rtl/vdiv_mode_ctl.sv
// Search/standard mode machine with saturating hit and miss runs.
module vdiv_mode_ctl
  import vdiv_pkg::*;
#(
  parameter int ENTER_HITS = 16,
  parameter int EXIT_MISS  = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  logic      insert,
  input  logic      is_std,
  output div_mode_t mode
);
  localparam int HW = $clog2(ENTER_HITS + 1);
  localparam int MW = $clog2(EXIT_MISS + 1);

  logic [HW-1:0] hits;
  logic [MW-1:0] misses;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_SEARCH;
      hits   <= '0;
      misses <= '0;
    end else if (mode == MODE_SEARCH) begin
      if (accept) begin
        if (!is_std) begin
          hits <= '0;
        end else if (hits == HW'(ENTER_HITS - 1)) begin
          mode   <= MODE_STD;
          hits   <= '0;
          misses <= '0;
        end else begin
          hits <= hits + 1'b1;
        end
      end
    end else begin
      if (accept) begin
        misses <= '0;
      end else if (insert) begin
        if (misses == MW'(EXIT_MISS - 1)) begin
          mode   <= MODE_SEARCH;
          hits   <= '0;
          misses <= '0;
        end else begin
          misses <= misses + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vdiv_pulse.sv
// Retriggerable fixed-width output pulse.
module vdiv_pulse #(
  parameter int PULSE_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic vout
);
  localparam int PW = $clog2(PULSE_W);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
      left <= '0;
    end else if (restart) begin
      vout <= 1'b1;
      left <= PW'(PULSE_W - 1);
    end else if (left != '0) begin
      vout <= 1'b1;
      left <= left - 1'b1;
    end else begin
      vout <= 1'b0;
    end
  end
endmodule

// File: rtl/vsync_countdown.sv
module vsync_countdown
  import vdiv_pkg::*;
#(
  parameter int FREE_LEN   = 525,
  parameter int SRCH_LO    = 488,
  parameter int SRCH_HI    = 576,
  parameter int WIN_LO     = 522,
  parameter int WIN_HI     = 528,
  parameter int PULSE_W    = 12,
  parameter int ENTER_HITS = 16,
  parameter int EXIT_MISS  = 6,
  parameter int CW         = $clog2(SRCH_HI + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync_i,
  output logic          vout_o,
  output logic          std_mode_o,
  output logic [CW-1:0] field_len_o
);
  div_mode_t     mode;
  logic          vs_q;
  logic          edge_det;
  logic [CW-1:0] hcnt;
  logic          was_wrap;
  logic [CW-1:0] wrap_len;
  logic          accept;
  logic          insert;
  logic          is_std;
  logic [CW:0]   len_sel;
  logic          restart;

  assign edge_det   = vsync_i && !vs_q;
  assign restart    = accept || insert;
  assign std_mode_o = (mode == MODE_STD);

  vdiv_window #(
    .CW(CW), .FREE_LEN(FREE_LEN), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_window (
    .mode(mode), .edge_det(edge_det), .hcnt(hcnt), .was_wrap(was_wrap),
    .wrap_len(wrap_len), .accept(accept), .insert(insert), .is_std(is_std),
    .len_sel(len_sel)
  );

  vdiv_mode_ctl #(
    .ENTER_HITS(ENTER_HITS), .EXIT_MISS(EXIT_MISS)
  ) u_mode (
    .clk(clk), .rst(rst), .accept(accept), .insert(insert), .is_std(is_std),
    .mode(mode)
  );

  vdiv_pulse #(
    .PULSE_W(PULSE_W)
  ) u_pulse (
    .clk(clk), .rst(rst), .restart(restart), .vout(vout_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q        <= 1'b0;
      hcnt        <= '0;
      was_wrap    <= 1'b0;
      wrap_len    <= '0;
      field_len_o <= '0;
    end else begin
      vs_q <= vsync_i;
      if (restart)
        hcnt <= CW'(1);
      else if (hcnt != '1)
        hcnt <= hcnt + 1'b1;
      if (accept) begin
        was_wrap    <= 1'b0;
        field_len_o <= len_sel[CW-1:0];
      end else if (insert) begin
        was_wrap <= 1'b1;
        wrap_len <= hcnt;
      end
    end
  end
endmodule

// File: rtl/vsync_countdown_chk.sv
module vsync_countdown_chk #(
  parameter int FREE_LEN = 525,
  parameter int SRCH_LO  = 488,
  parameter int SRCH_HI  = 576,
  parameter int WIN_HI   = 528,
  parameter int PULSE_W  = 12,
  parameter int CW       = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          vout_o,
  input logic          std_mode_o,
  input logic [CW-1:0] field_len_o,
  input logic [CW-1:0] hcnt,
  input logic          restart,
  input logic          accept,
  input logic          insert,
  input logic          is_std
);
  localparam int SCW = $clog2(PULSE_W + 1);

  logic [SCW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst)
      since <= SCW'(PULSE_W);
    else if (restart)
      since <= '0;
    else if (since != SCW'(PULSE_W))
      since <= since + 1'b1;
  end

  AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (rst)
    !std_mode_o |-> hcnt <= CW'(FREE_LEN)); // R2
  AST_PULSE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    vout_o == (since < SCW'(PULSE_W))); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    field_len_o != '0 |-> (field_len_o >= CW'(SRCH_LO) && field_len_o <= CW'(SRCH_HI))); // R4
  AST_MODE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(std_mode_o) |-> $past(accept && is_std)); // R6
  AST_STD_BOUND: assert property (@(posedge clk) disable iff (rst)
    std_mode_o |-> hcnt <= CW'(WIN_HI)); // R8
  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(std_mode_o) |-> $past(insert)); // R9
endmodule

bind vsync_countdown vsync_countdown_chk #(
  .FREE_LEN(FREE_LEN), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
  .WIN_HI(WIN_HI), .PULSE_W(PULSE_W), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .vout_o(vout_o), .std_mode_o(std_mode_o),
  .field_len_o(field_len_o), .hcnt(hcnt), .restart(restart),
  .accept(accept), .insert(insert), .is_std(is_std)
);

// File: tb/test_vsync_countdown.sv
module test_vsync_countdown;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vsync = 1'b0;
  logic       vout;
  logic       stdm;
  logic [9:0] flen;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int rise_last = 0;
  int rise_prev = 0;
  int run = 0;
  int last_width = 0;
  logic vprev = 1'b0;

  always #4 clk = ~clk;

  vsync_countdown i_vsync_countdown (
    .clk(clk), .rst(rst), .vsync_i(vsync), .vout_o(vout),
    .std_mode_o(stdm), .field_len_o(flen)
  );

  // observe just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst) begin
      if (vout && !vprev) begin
        rise_cnt++;
        rise_prev = rise_last;
        rise_last = cyc;
      end
      if (vout) run++;
      else if (vprev) begin
        last_width = run;
        run = 0;
      end
      vprev = vout;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_after(input int n);
    repeat (n - 1) @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic wait_rise();
    int n0 = rise_cnt;
    while (rise_cnt == n0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 vout in reset", int'(vout), 0);
    chk("R1 mode in reset", int'(stdm), 0);
    chk("R1 field_len in reset", int'(flen), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 vout after reset", int'(vout), 0);
    chk("R1 field_len after reset", int'(flen), 0);

    // free run
    wait_rise();
    wait_rise();
    chk("R2 free-run period", rise_last - rise_prev, 525);
    wait_rise();
    chk("R2 free-run period again", rise_last - rise_prev, 525);
    repeat (14) @(negedge clk);
    chk("R3 pulse width free-run", last_width, 12);

    // search window low side
    wait_rise();
    sync_after(480);
    chk("R4 early sync gives no pulse", int'(vout), 0);
    chk("R5 early sync leaves length", int'(flen), 0);
    wait_rise();
    chk("R2 period after ignored sync", rise_last - rise_prev, 525);
    sync_after(488);
    chk("R4 sync at 488 restarts", int'(vout), 1);
    chk("R5 length 488", int'(flen), 488);

    // late side after a self restart
    sync_after(577);
    chk("R4 length 577 rejected", int'(flen), 488);
    chk("R4 length 577 gives no pulse", int'(vout), 0);
    wait_rise();
    sync_after(51);
    chk("R4 late sync length 576 accepted", int'(vout), 1);
    chk("R5 late length 576", int'(flen), 576);

    // entry to standard mode
    for (int i = 0; i < 15; i++) sync_after(525);
    chk("R6 still search after 15", int'(stdm), 0);
    chk("R5 length 525", int'(flen), 525);
    sync_after(525);
    chk("R6 standard after 16", int'(stdm), 1);
    chk("R3 pulse starts after sync edge", int'(vout), 1);
    repeat (13) @(negedge clk);
    chk("R3 pulse width after sync", last_width, 12);
    chk("R3 pulse ended", int'(vout), 0);

    // standard window edges
    sync_after(522 - 13);
    chk("R7 sync at 522 accepted", int'(flen), 522);
    chk("R7 sync at 522 pulse", int'(vout), 1);
    sync_after(528);
    chk("R8 sync at 528 wins over insertion", int'(flen), 528);
    chk("R7 sync at 528 pulse", int'(vout), 1);
    sync_after(300);
    chk("R7 mid-field sync ignored", int'(vout), 0);
    wait_rise();
    chk("R8 inserted at 528", rise_last - rise_prev, 528);
    chk("R5 insertion leaves length", int'(flen), 528);
    chk("R8 still standard", int'(stdm), 1);
    sync_after(521);
    chk("R7 sync at 521 ignored", int'(vout), 0);
    wait_rise();
    chk("R8 second insertion", rise_last - rise_prev, 528);
    sync_after(525);
    chk("R9 accepted sync clears misses", int'(flen), 525);

    // exit after six misses
    for (int i = 0; i < 5; i++) begin
      wait_rise();
      chk("R8 flywheel period", rise_last - rise_prev, 528);
    end
    chk("R9 still standard after 5 misses", int'(stdm), 1);
    wait_rise();
    chk("R9 search after 6 misses", int'(stdm), 0);

    // nonstandard field breaks the run
    for (int i = 0; i < 10; i++) sync_after(525);
    sync_after(540);
    chk("R4 late length 540", int'(flen), 540);
    for (int i = 0; i < 15; i++) sync_after(525);
    chk("R6 run restarted by 540 field", int'(stdm), 0);
    sync_after(525);
    chk("R6 standard after fresh 16", int'(stdm), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule